// File: doc/BRIEF.md
# Network Response Frame Transmitter

This block sends the two short reply frames used on a token-passing network: a positive reply and a negative reply. Each frame goes out as a serial bit stream. A frame is a run of marking bits, then a short start pattern, then one 8-bit control character. The positive reply carries the character 0x86 and the negative reply carries 0x15. The receive side of the node reports two kinds of event: a data packet was received, or a free-buffer enquiry arrived. The block remembers which of these events are still waiting for an answer. It starts a frame only when the request fits one of them.

A requester drives a one-cycle request that names the reply kind. The request is taken only while the block is idle. After a request is taken, the first bit goes out on the next bit-clock enable strobe. Each following strobe moves the output to the next bit. The line-driver side watches `tx_busy` while the frame is on the line and gets a one-cycle `tx_done` when it ends. A request that no waiting event allows is dropped, and the block raises a one-cycle error flag.

Top module: `arc_resp_tx`

## Requirements
- R1: After reset, `ser_out`, `tx_busy`, `tx_done` and `req_err` are 0 and no event is waiting, so any request made before an event arrives is refused.
- R2: A positive reply frame carries 17 bits in this order: six 1s, then the start pattern 1,1,0, then 0x86 sent least significant bit first.
- R3: A negative reply frame has the same shape as a positive one but carries 0x15 as its character, least significant bit first.
- R4: The first frame bit appears at the first `bit_en` strobe after a request is taken. Each bit then holds for exactly one strobe period. `ser_out` is 0 whenever no frame bit is being sent.
- R5: `tx_busy` is 1 from the first frame bit up to the strobe that ends the last bit. `tx_done` is a one-cycle pulse in the cycle after that strobe, and `tx_busy` is 0 during the pulse.
- R6: A positive request (`req_nak`=0) is legal when a received packet or an enquiry is waiting. It uses up the waiting packet if there is one, and otherwise the waiting enquiry.
- R7: A negative request (`req_nak`=1) is legal only when an enquiry is waiting, and it uses that enquiry up.
- R8: An illegal request taken while idle sends no frame, changes no waiting event, and sets `req_err` for exactly the one cycle after the request.
- R9: A request made while a frame is waiting for its first strobe or is being sent is ignored. It raises no error and leaves the waiting events unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit-interval strobe, one cycle wide |
| pkt_rcvd | input | 1 | Pulse: a data packet was received and needs a positive reply |
| enq_rcvd | input | 1 | Pulse: a free-buffer enquiry arrived and needs a reply |
| req_valid | input | 1 | Reply request strobe |
| req_nak | input | 1 | Reply kind: 0 positive, 1 negative |
| ser_out | output | 1 | Serial frame data |
| tx_busy | output | 1 | A frame is on the line |
| tx_done | output | 1 | One-cycle pulse after the final bit |
| req_err | output | 1 | One-cycle pulse: the request was refused |

## Verification
A request driven before edge N is decided at edge N. Its `req_err` is therefore read in the half cycle after that edge. A taken request shows no output change until the bench raises `bit_en`. The bench holds the strobe low for two cycles after a request, to confirm the armed wait keeps `tx_busy` and `ser_out` at 0. Bit k is read just after the edge of strobe k, and read again on the non-strobe cycles of that period to confirm it holds. `tx_done` is read just after the edge of strobe 17 and once more one cycle later, to confirm the pulse lasts a single cycle. Each refused or ignored request is followed by a later request whose result depends on which events are still waiting.

// File: rtl/arc_resp_pkg.sv
// Package: shared frame layout, character codes and sequencer states
// for the response frame transmitter.
package arc_resp_pkg;
    localparam int unsigned ALERT_BITS = 6;
    localparam int unsigned START_BITS = 3;
    localparam logic [START_BITS-1:0] START_PAT = 3'b011; // sent bit0 first: 1,1,0
    localparam int unsigned CHAR_BITS  = 8;
    localparam logic [CHAR_BITS-1:0] ACK_CHAR = 8'h86;
    localparam logic [CHAR_BITS-1:0] NAK_CHAR = 8'h15;
    localparam int unsigned FRAME_BITS = ALERT_BITS + START_BITS + CHAR_BITS;
    localparam int unsigned IDX_W      = $clog2(FRAME_BITS);

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ARMED = 2'd1,
        SQ_SEND  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/arc_resp_ctx.sv
// Module: arc_resp_ctx
// Keeps track of which events still need a reply (a received packet, a
// free-buffer enquiry) and decides whether a request may start a frame.
// Assumes: idle comes from the sequencer; requests are single-cycle pulses.
module arc_resp_ctx (
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_rcvd,
    input  logic enq_rcvd,
    input  logic req_valid,
    input  logic req_nak,
    input  logic idle,
    output logic start,
    output logic err
);
    logic pkt_q, enq_q;
    logic take, legal, clr_pkt, clr_enq;

    // Legality of a request and which waiting event it uses up.
    always_comb begin
        take    = req_valid & idle;
        legal   = req_nak ? enq_q : (pkt_q | enq_q);
        start   = take & legal;
        clr_pkt = start & ~req_nak & pkt_q;
        clr_enq = start & (req_nak | ~pkt_q);
    end

    // Event flags (a new event wins over a clear) and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_q <= 1'b0;
            enq_q <= 1'b0;
            err   <= 1'b0;
        end else begin
            pkt_q <= (pkt_q & ~clr_pkt) | pkt_rcvd;
            enq_q <= (enq_q & ~clr_enq) | enq_rcvd;
            err   <= take & ~legal;
        end
    end

    // R7: a negative request can only start while an enquiry is waiting.
    assert_nak_needs_enq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && req_nak) |=> ($past(enq_q) && (!enq_q || $past(enq_rcvd))));
    // R9: while not idle no request is refused or started.
    assert_busy_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !idle) |=> !err);
endmodule

// File: rtl/arc_resp_frame.sv
// Module: arc_resp_frame
// Builds the whole frame bit pattern (index 0 goes first) for the chosen
// reply kind: marking run, start pattern, then the character LSB first.
// Assumes: the kind stays stable for the length of a frame.
module arc_resp_frame
    import arc_resp_pkg::*;
#(
    parameter int unsigned N_ALERT = ALERT_BITS,
    parameter int unsigned N_START = START_BITS,
    parameter int unsigned N_CHAR  = CHAR_BITS,
    localparam int unsigned N_ALL  = N_ALERT + N_START + N_CHAR
) (
    input  logic [N_START-1:0] start_pat,
    input  logic [N_CHAR-1:0]  pos_code,
    input  logic [N_CHAR-1:0]  neg_code,
    input  logic               is_nak,
    output logic [N_ALL-1:0]   pattern
);
    logic [N_CHAR-1:0] code;

    // Pick the character for this reply kind.
    always_comb code = is_nak ? neg_code : pos_code;

    // Lay out the three fields of the frame.
    for (genvar i = 0; i < N_ALERT; i++) begin : g_alert
        assign pattern[i] = 1'b1;
    end
    for (genvar i = 0; i < N_START; i++) begin : g_start
        assign pattern[N_ALERT+i] = start_pat[i];
    end
    for (genvar i = 0; i < N_CHAR; i++) begin : g_char
        assign pattern[N_ALERT+N_START+i] = code[i];
    end
endmodule

// File: rtl/arc_resp_seq.sv
// Module: arc_resp_seq
// Bit sequencer: once a frame is taken it waits for the first strobe,
// steps through the frame one bit per strobe, then pulses done.
// Assumes: bit_en is a one-cycle strobe; start comes only while idle.
module arc_resp_seq
    import arc_resp_pkg::*;
#(
    parameter int unsigned N_BITS = FRAME_BITS,
    localparam int unsigned W     = $clog2(N_BITS),
    localparam logic [W-1:0] LAST = W'(N_BITS - 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic         start,
    input  logic         start_nak,
    output logic         idle,
    output logic         busy,
    output logic         done,
    output logic         kind_nak,
    output logic [W-1:0] bit_idx
);
    seq_state_t state;

    // Status seen by the context logic and the output mux.
    always_comb begin
        idle = (state == SQ_IDLE);
        busy = (state == SQ_SEND);
    end

    // State, bit index, reply kind and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SQ_IDLE;
            bit_idx  <= '0;
            done     <= 1'b0;
            kind_nak <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SQ_IDLE: if (start) begin
                    state    <= SQ_ARMED;
                    kind_nak <= start_nak;
                end
                SQ_ARMED: if (bit_en) begin
                    state   <= SQ_SEND;
                    bit_idx <= '0;
                end
                SQ_SEND: if (bit_en) begin
                    if (bit_idx == LAST) begin
                        state <= SQ_IDLE;
                        done  <= 1'b1;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R9: the context logic only starts a frame while the sequencer is idle.
    assert_start_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> idle);
    // R5: done follows a busy cycle, and done lasts a single cycle.
    assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(busy) && !busy));
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4: the bit index moves only on a strobe and never passes the last bit.
    assert_hold_between_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_en) |=> (busy && $stable(bit_idx)));
    assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bit_idx <= LAST));
endmodule

// File: rtl/arc_resp_tx.sv
// Module: arc_resp_tx (top)
// Response frame transmitter: context check, frame layout and bit sequencer.
// Assumes: synchronous active-low reset; bit_en sets the bit rate.
module arc_resp_tx
    import arc_resp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic pkt_rcvd,
    input  logic enq_rcvd,
    input  logic req_valid,
    input  logic req_nak,
    output logic ser_out,
    output logic tx_busy,
    output logic tx_done,
    output logic req_err
);
    logic idle, start, kind_nak;
    logic [IDX_W-1:0]      bit_idx;
    logic [FRAME_BITS-1:0] pattern;

    arc_resp_ctx u_ctx (
        .clk(clk), .rst_n(rst_n), .pkt_rcvd(pkt_rcvd), .enq_rcvd(enq_rcvd),
        .req_valid(req_valid), .req_nak(req_nak), .idle(idle),
        .start(start), .err(req_err)
    );

    arc_resp_seq #(.N_BITS(FRAME_BITS)) u_seq (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start),
        .start_nak(req_nak), .idle(idle), .busy(tx_busy), .done(tx_done),
        .kind_nak(kind_nak), .bit_idx(bit_idx)
    );

    arc_resp_frame #(.N_ALERT(ALERT_BITS), .N_START(START_BITS), .N_CHAR(CHAR_BITS)) u_frame (
        .start_pat(START_PAT), .pos_code(ACK_CHAR), .neg_code(NAK_CHAR),
        .is_nak(kind_nak), .pattern(pattern)
    );

    // Serial output: the current frame bit while sending, 0 otherwise.
    always_comb ser_out = tx_busy ? pattern[bit_idx] : 1'b0;

    // R4: the line rests at 0 outside a frame.
    assert_line_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> !ser_out);
    // R8: a refused request never coincides with a frame on the line.
    assert_err_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> !tx_busy);
endmodule

// File: tb/arc_resp_tx_bench.sv
// Bench for arc_resp_tx: runs every legal and illegal request against each
// mix of waiting events and checks every frame bit against arithmetic.
module arc_resp_tx_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0, pkt_rcvd = 1'b0, enq_rcvd = 1'b0;
    logic req_valid = 1'b0, req_nak = 1'b0;
    logic ser_out, tx_busy, tx_done, req_err;
    int checks = 0;
    int errors = 0;

    localparam int PERIOD = 3; // clock cycles per bit strobe

    always #10 clk = ~clk; // 50 MHz

    arc_resp_tx u_arc_resp_tx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pkt_rcvd(pkt_rcvd),
        .enq_rcvd(enq_rcvd), .req_valid(req_valid), .req_nak(req_nak),
        .ser_out(ser_out), .tx_busy(tx_busy), .tx_done(tx_done), .req_err(req_err)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected frame bit k, computed from the layout in R2/R3.
    function automatic logic exp_bit(input logic nak, input int k);
        logic [7:0] code;
        code = nak ? 8'h15 : 8'h86;
        if (k < 6) return 1'b1;
        if (k < 8) return 1'b1;
        if (k == 8) return 1'b0;
        return code[k-9];
    endfunction

    task automatic pulse_event(input logic pkt, input logic enq);
        @(negedge clk); pkt_rcvd = pkt; enq_rcvd = enq;
        @(negedge clk); pkt_rcvd = 1'b0; enq_rcvd = 1'b0;
    endtask

    // Sends one frame after acceptance; poke issues stray requests (R9).
    task automatic run_frame(input logic nak, input logic poke);
        string rq;
        rq = nak ? "R3" : "R2";
        for (int c = 0; c < 2; c++) begin
            if (poke && c == 0) begin req_valid = 1'b1; req_nak = ~nak; end
            @(negedge clk);
            req_valid = 1'b0;
            check("R4", "armed busy", tx_busy, 0);
            check("R4", "armed line", ser_out, 0);
            check("R9", "armed poke err", req_err, 0);
        end
        for (int k = 0; k < 17; k++) begin
            bit_en = 1'b1;
            if (poke && k == 3) begin req_valid = 1'b1; req_nak = 1'b1; end
            @(negedge clk);
            bit_en = 1'b0; req_valid = 1'b0;
            check("R5", "busy in frame", tx_busy, 1);
            check(rq, $sformatf("bit %0d", k), ser_out, exp_bit(nak, k));
            check("R9", "send poke err", req_err, 0);
            for (int h = 1; h < PERIOD; h++) begin
                @(negedge clk);
                check("R4", $sformatf("hold bit %0d", k), ser_out, exp_bit(nak, k));
            end
        end
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        check("R5", "done pulse", tx_done, 1);
        check("R5", "busy at done", tx_busy, 0);
        check("R4", "line after frame", ser_out, 0);
        @(negedge clk);
        check("R5", "done single", tx_done, 0);
    endtask

    // Request; expect acceptance (frame follows) or refusal (err, no frame).
    task automatic request(input logic nak, input logic ok, input string rq, input logic poke);
        @(negedge clk);
        req_valid = 1'b1; req_nak = nak;
        @(negedge clk);
        req_valid = 1'b0;
        check(rq, "req_err", req_err, ok ? 0 : 1);
        if (ok) run_frame(nak, poke);
        else begin
            @(negedge clk);
            check("R8", "err single", req_err, 0);
            for (int s = 0; s < 2; s++) begin
                bit_en = 1'b1;
                @(negedge clk);
                bit_en = 1'b0;
                check("R8", "no frame busy", tx_busy, 0);
                check("R8", "no frame line", ser_out, 0);
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "ser_out", ser_out, 0);
        check("R1", "busy", tx_busy, 0);
        check("R1", "done", tx_done, 0);
        check("R1", "err", req_err, 0);
        rst_n = 1'b1;
        // R1: nothing waiting after reset
        request(1'b0, 1'b0, "R1", 1'b0);
        request(1'b1, 1'b0, "R1", 1'b0);
        // R7: packet waiting alone does not allow a negative reply
        pulse_event(1'b1, 1'b0);
        request(1'b1, 1'b0, "R7", 1'b0);
        request(1'b0, 1'b1, "R6", 1'b0);
        request(1'b0, 1'b0, "R6", 1'b0);
        // R7: enquiry allows a negative reply and is used up by it
        pulse_event(1'b0, 1'b1);
        request(1'b1, 1'b1, "R7", 1'b0);
        request(1'b0, 1'b0, "R7", 1'b0);
        // R6: both waiting, positive uses packet first, then enquiry
        pulse_event(1'b1, 1'b1);
        request(1'b0, 1'b1, "R6", 1'b0);
        request(1'b1, 1'b1, "R6", 1'b0);
        request(1'b0, 1'b0, "R6", 1'b0);
        // R6: enquiry alone allows a positive reply
        pulse_event(1'b0, 1'b1);
        request(1'b0, 1'b1, "R6", 1'b0);
        request(1'b1, 1'b0, "R6", 1'b0);
        // R9: stray requests while armed and sending change nothing
        pulse_event(1'b1, 1'b1);
        request(1'b0, 1'b1, "R9", 1'b1);
        request(1'b1, 1'b1, "R9", 1'b0);
        request(1'b1, 1'b0, "R9", 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule